// File: doc/BRIEF.md
# Flash Power-Mode Controller

This block sits between an asynchronous host bus (active-low chip enable, output enable and write enable, a 13-bit address and an 8-bit data bus) and the internals of a memory-mapped flash device. It brings the bus strobes into the system clock domain and recognises each read and write cycle once. It then tracks which of three operating modes the device is in: Reset, Normal or Deep Power-Down. From that mode it gates register writes, forces read data to zero in Reset, stops driving the data bus in Deep Power-Down, and drives a power-enable output for the internal regulators and buffers.

Software changes mode with a two-step unlock. The first write goes to the control register at 0x1000 and carries a 2-bit mode code in bits [1:0]. The second goes to the confirmation register at 0x1001 and must carry the 8-bit complement of the first. A power-down request takes effect only once the chip enable is released. The device wakes after four consecutive reads of address 0x1FFF, or on an edge of an external power-down pin whose polarity software chooses. An active-low reset pin forces power-down while held, and the device comes out of it into Reset. A small register file (power-down control and scratch registers) keeps its contents through every power-down round trip.

The FSM states are ST_RESET, ST_NORMAL, ST_PD_PEND (power-down confirmed, waiting for the chip enable to be released), ST_DPD (powered down) and ST_RST_HOLD (reset pin held). The transitions are:
- unlock: ST_RESET or ST_NORMAL to the state the code names. Code 00 goes to ST_RESET, 01 to ST_NORMAL and 10 to ST_PD_PEND.
- release: ST_PD_PEND to ST_DPD once the chip enable is negated.
- wake: ST_DPD back to the saved mode, by the read sequence or by the pin edge.
- pin-hold: any state to ST_RST_HOLD while the reset pin is low.
- pin-release: ST_RST_HOLD to ST_RESET.

Top module: `pmode_ctrl`

## Requirements
- R1: A write cycle is chip enable and write enable both low. A read cycle is chip enable and output enable both low. Each cycle acts once, when its strobe is released. A write strobe without chip enable writes nothing, and a read cycle writes nothing.
- R2: Mode codes are 00 Reset, 01 Normal and 10 Deep Power-Down, reported on `mode`. A write of code C to 0x1000, followed as the very next write by ~C (8-bit) to 0x1001, moves the block to mode C. After reset the mode is Reset (00).
- R3: The mode stays unchanged in two cases: the confirmation value is not the complement, or some other write comes between the two steps.
- R4: In Reset, every write except those to 0x1000 and 0x1001 is ignored.
- R5: In Reset, every read drives the data bus with 0x00.
- R6: A confirmed code 10 takes effect only after chip enable is negated. `pwr_en` is low exactly while the mode is Deep Power-Down.
- R7: In Deep Power-Down, writes (including unlock writes) have no effect and `rdata_oe` stays low during reads.
- R8: Four consecutive reads of 0x1FFF end Deep Power-Down. A read of any other address restarts the count.
- R9: An edge on `pd_pin` ends Deep Power-Down. Bit 0 of the power-down control register at 0x1002 selects the edge: 0 means rising, 1 means falling. An edge of the other polarity does nothing.
- R10: Leaving Deep Power-Down returns the mode held before it. Register contents are unchanged by the round trip.
- R11: While `rstin_n` is low, the mode is Deep Power-Down and `pwr_en` is low. On release the mode becomes Reset.
- R12: In Normal, reads return the last byte written to 0x1000, the control register at 0x1002 and the scratch registers at 0x1004 to 0x1007. Any other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| ce_n | input | 1 | Bus chip enable, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| addr | input | 13 | Bus address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data |
| rdata_oe | output | 1 | Data bus drive enable |
| rstin_n | input | 1 | Reset pin, active low |
| pd_pin | input | 1 | External power-down wake pin |
| mode | output | 2 | Current mode code |
| pwr_en | output | 1 | Enable for internal regulators and buffers |

## Verification
A wrong FSM state shows on `mode` and `pwr_en` a few clocks after the bus strobe or pin that caused it: two synchroniser stages plus one state register. The directed tests sample there. A stale unlock or a miscounted wake sequence shows up as a mode that changes when it should not, or does not change when it should, after the next cycle. Lost register contents appear on the first read-back after a power-down round trip.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

    typedef enum logic [1:0] {
        MD_RESET  = 2'b00,
        MD_NORMAL = 2'b01,
        MD_DPD    = 2'b10
    } mode_t;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_NORMAL,
        ST_PD_PEND,
        ST_DPD,
        ST_RST_HOLD
    } state_t;

endpackage

// File: rtl/pmode_sync.sv
module pmode_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/pmode_busif.sv
module pmode_busif #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_s,
    input  logic              oe_n_s,
    input  logic              we_n_s,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              wr_done_o,
    output logic              rd_done_o,
    output logic [ADDR_W-1:0] cap_addr_o,
    output logic [DATA_W-1:0] cap_data_o,
    output logic              sel_o
);
    logic wr_act, rd_act, wr_q, rd_q;

    assign wr_act = !ce_n_s && !we_n_s;
    assign rd_act = !ce_n_s && !oe_n_s;
    assign sel_o  = !ce_n_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q       <= 1'b0;
            rd_q       <= 1'b0;
            cap_addr_o <= '0;
            cap_data_o <= '0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
            if (wr_act || rd_act) cap_addr_o <= addr_i;
            if (wr_act)           cap_data_o <= wdata_i;
        end
    end

    // a cycle acts once, when its strobe is released
    assign wr_done_o = wr_q && !wr_act;
    assign rd_done_o = rd_q && !rd_act;

    p_one_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done_o |=> !wr_done_o);
    p_one_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_o |=> !rd_done_o);
endmodule

// File: rtl/pmode_regs.sv
module pmode_regs #(
    parameter int                ADDR_W     = 13,
    parameter int                DATA_W     = 8,
    parameter int                NREGS      = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 13'h1000,
    parameter logic [ADDR_W-1:0] PDCTL_ADDR = 13'h1002,
    parameter logic [ADDR_W-1:0] SCR_BASE   = 13'h1004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              ctrl_wr_en_i,
    input  logic              frozen_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              pd_pol_o
);
    logic [DATA_W-1:0]             ctrl_q, pdctl_q;
    logic [NREGS-1:0][DATA_W-1:0]  scratch_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            pdctl_q <= '0;
        end else begin
            if (ctrl_wr_en_i) ctrl_q <= wr_data_i;
            if (wr_en_i && wr_addr_i == PDCTL_ADDR) pdctl_q <= wr_data_i;
        end
    end

    for (genvar g = 0; g < NREGS; g++) begin : g_scr
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(SCR_BASE + g);
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= '0;
            else if (wr_en_i && wr_addr_i == MY_ADDR) q <= wr_data_i;
        end
        assign scratch_w[g] = q;
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == CTRL_ADDR)  rd_data_o = ctrl_q;
        if (rd_addr_i == PDCTL_ADDR) rd_data_o = pdctl_q;
        for (int i = 0; i < NREGS; i++) begin
            if (rd_addr_i == ADDR_W'(SCR_BASE + i)) rd_data_o = scratch_w[i];
        end
    end

    assign pd_pol_o = pdctl_q[0];

    p_frozen_regs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_i && $past(frozen_i)) |-> ($stable(scratch_w) && $stable(pdctl_q) && $stable(ctrl_q)));
endmodule

// File: rtl/pmode_fsm.sv
module pmode_fsm
    import pmode_pkg::*;
#(
    parameter int                ADDR_W     = 13,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 13'h1000,
    parameter logic [ADDR_W-1:0] CONF_ADDR  = 13'h1001,
    parameter logic [ADDR_W-1:0] WAKE_ADDR  = 13'h1FFF,
    parameter int                WAKE_READS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_done_i,
    input  logic              rd_done_i,
    input  logic [ADDR_W-1:0] cap_addr_i,
    input  logic [DATA_W-1:0] cap_data_i,
    input  logic              sel_i,
    input  logic              rstin_i,
    input  logic              pd_i,
    input  logic              pd_pol_i,
    output mode_t             mode_o,
    output logic              pwr_en_o,
    output logic              reg_wr_en_o,
    output logic              ctrl_wr_en_o
);
    localparam int              CNT_W = $clog2(WAKE_READS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_READS - 1);

    state_t            state_q, state_d;
    mode_t             ret_q;
    logic              armed_q;
    logic [DATA_W-1:0] arm_val_q;
    logic [CNT_W-1:0]  wake_cnt_q;
    logic              pd_prev_q;

    logic live, is_ctrl, is_conf, commit, read_wake, pin_edge;

    assign live      = (state_q == ST_RESET) || (state_q == ST_NORMAL);
    assign is_ctrl   = cap_addr_i == CTRL_ADDR;
    assign is_conf   = cap_addr_i == CONF_ADDR;
    assign commit    = live && wr_done_i && is_conf && armed_q && (cap_data_i == ~arm_val_q);
    assign read_wake = rd_done_i && (cap_addr_i == WAKE_ADDR) && (wake_cnt_q == LAST);
    assign pin_edge  = pd_pol_i ? (pd_prev_q && !pd_i) : (!pd_prev_q && pd_i);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!rstin_i) begin
            state_d = ST_RST_HOLD;
        end else begin
            unique case (state_q)
                ST_RESET, ST_NORMAL: begin
                    if (commit) begin
                        unique case (arm_val_q[1:0])
                            2'b00:   state_d = ST_RESET;
                            2'b01:   state_d = ST_NORMAL;
                            2'b10:   state_d = ST_PD_PEND;
                            default: state_d = state_q;
                        endcase
                    end
                end
                ST_PD_PEND:  if (!sel_i) state_d = ST_DPD;
                ST_DPD:      if (read_wake || pin_edge)
                                 state_d = (ret_q == MD_NORMAL) ? ST_NORMAL : ST_RESET;
                ST_RST_HOLD: state_d = ST_RESET;
                default:     state_d = ST_RESET;
            endcase
        end
    end

    // state register and sequence bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_RESET;
            ret_q      <= MD_RESET;
            armed_q    <= 1'b0;
            arm_val_q  <= '0;
            wake_cnt_q <= '0;
            pd_prev_q  <= 1'b0;
        end else begin
            state_q   <= state_d;
            pd_prev_q <= pd_i;
            if (commit && arm_val_q[1:0] == 2'b10)
                ret_q <= (state_q == ST_NORMAL) ? MD_NORMAL : MD_RESET;
            if (!live) begin
                armed_q <= 1'b0;
            end else if (wr_done_i) begin
                armed_q <= is_ctrl;
                if (is_ctrl) arm_val_q <= cap_data_i;
            end
            if (state_q != ST_DPD)
                wake_cnt_q <= '0;
            else if (rd_done_i)
                wake_cnt_q <= (cap_addr_i == WAKE_ADDR) ? wake_cnt_q + CNT_W'(1) : '0;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RESET:            mode_o = MD_RESET;
            ST_NORMAL:           mode_o = MD_NORMAL;
            ST_PD_PEND:          mode_o = ret_q;
            ST_DPD, ST_RST_HOLD: mode_o = MD_DPD;
            default:             mode_o = MD_RESET;
        endcase
        pwr_en_o     = (mode_o != MD_DPD);
        reg_wr_en_o  = wr_done_i && (state_q == ST_NORMAL);
        ctrl_wr_en_o = wr_done_i && live && is_ctrl;
    end

    p_pin_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && !rstin_i) |=> (state_q == ST_RST_HOLD));
    p_pin_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RST_HOLD && rstin_i) |=> (state_q == ST_RESET));
    p_pend_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PD_PEND && sel_i && rstin_i) |=> (state_q == ST_PD_PEND));
    p_bad_confirm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done_i && is_conf && rstin_i && (!armed_q || cap_data_i != ~arm_val_q))
        |=> (state_q == $past(state_q)));
    p_wake_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DPD) |=> (state_q == ST_DPD || state_q == ST_RST_HOLD || mode_o == $past(ret_q)));
endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
    import pmode_pkg::*;
#(
    parameter int                ADDR_W     = 13,
    parameter int                DATA_W     = 8,
    parameter int                NREGS      = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 13'h1000,
    parameter logic [ADDR_W-1:0] CONF_ADDR  = 13'h1001,
    parameter logic [ADDR_W-1:0] PDCTL_ADDR = 13'h1002,
    parameter logic [ADDR_W-1:0] SCR_BASE   = 13'h1004,
    parameter logic [ADDR_W-1:0] WAKE_ADDR  = 13'h1FFF,
    parameter int                WAKE_READS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    input  logic              rstin_n,
    input  logic              pd_pin,
    output logic [1:0]        mode,
    output logic              pwr_en
);
    localparam int NSYNC = 5;

    logic [NSYNC-1:0]  pins_s;
    logic              wr_done, rd_done, sel, reg_wr_en, ctrl_wr_en, pd_pol;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data, reg_rd;
    mode_t             mode_w;

    // order: pd, rstin, we, oe, ce
    pmode_sync #(.W(NSYNC), .RST_VAL(5'b01111)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({pd_pin, rstin_n, we_n, oe_n, ce_n}),
        .q_o(pins_s)
    );

    pmode_busif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .ce_n_s(pins_s[0]), .oe_n_s(pins_s[1]), .we_n_s(pins_s[2]),
        .addr_i(addr), .wdata_i(wdata),
        .wr_done_o(wr_done), .rd_done_o(rd_done),
        .cap_addr_o(cap_addr), .cap_data_o(cap_data), .sel_o(sel)
    );

    pmode_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
        .CONF_ADDR(CONF_ADDR), .WAKE_ADDR(WAKE_ADDR), .WAKE_READS(WAKE_READS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wr_done_i(wr_done), .rd_done_i(rd_done),
        .cap_addr_i(cap_addr), .cap_data_i(cap_data), .sel_i(sel),
        .rstin_i(pins_s[3]), .pd_i(pins_s[4]), .pd_pol_i(pd_pol),
        .mode_o(mode_w), .pwr_en_o(pwr_en),
        .reg_wr_en_o(reg_wr_en), .ctrl_wr_en_o(ctrl_wr_en)
    );

    pmode_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS),
        .CTRL_ADDR(CTRL_ADDR), .PDCTL_ADDR(PDCTL_ADDR), .SCR_BASE(SCR_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(reg_wr_en), .ctrl_wr_en_i(ctrl_wr_en),
        .frozen_i(mode_w == MD_DPD),
        .wr_addr_i(cap_addr), .wr_data_i(cap_data),
        .rd_addr_i(addr), .rd_data_o(reg_rd), .pd_pol_o(pd_pol)
    );

    always_comb begin
        mode     = mode_w;
        rdata    = (mode_w == MD_RESET) ? '0 : reg_rd;
        rdata_oe = !ce_n && !oe_n && (mode_w != MD_DPD);
    end

    p_reset_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RESET && rdata_oe) |-> (rdata == '0));
    p_dpd_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_DPD) |-> !rdata_oe);
    p_dpd_power_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> (mode == MD_DPD));
endmodule

// File: tb/test_pmode_ctrl.sv
module test_pmode_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_oe;
    logic        rstin_n = 1'b1, pd_pin = 1'b0;
    logic [1:0]  mode;
    logic        pwr_en;

    int  n_tests = 0, n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    pmode_ctrl i_pmode_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .rstin_n(rstin_n), .pd_pin(pd_pin), .mode(mode), .pwr_en(pwr_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
        wait_clk(4);
        we_n = 1'b1; ce_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic bus_read(input logic [12:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        wait_clk(4);
        d = rdata; oe = rdata_oe;
        oe_n = 1'b1; ce_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic read_chk(input string req, input logic [12:0] a, input logic [7:0] exp);
        logic [7:0] d; logic oe;
        bus_read(a, d, oe);
        chk(req, {31'b0, oe}, 32'd1);
        chk(req, {24'b0, d}, {24'b0, exp});
    endtask

    task automatic unlock(input logic [7:0] code);
        bus_write(13'h1000, code);
        bus_write(13'h1001, ~code);
    endtask

    task automatic t_reset_state;
        chk("R2 reset mode", {30'b0, mode}, 32'd0);
        chk("R6 reset power", {31'b0, pwr_en}, 32'd1);
        read_chk("R5 scratch read", 13'h1004, 8'h00);
        read_chk("R5 ctrl read", 13'h1000, 8'h00);
    endtask

    task automatic t_reset_writes;
        bus_write(13'h1004, 8'hA5);
        bus_write(13'h1002, 8'h01);
    endtask

    task automatic t_bad_unlock;
        bus_write(13'h1000, 8'h01);
        bus_write(13'h1001, 8'h00);
        chk("R3 wrong complement", {30'b0, mode}, 32'd0);
        bus_write(13'h1000, 8'h01);
        bus_write(13'h1005, 8'h33);
        bus_write(13'h1001, 8'hFE);
        chk("R3 intervening write", {30'b0, mode}, 32'd0);
    endtask

    task automatic t_unlock;
        unlock(8'h01);
        chk("R2 unlock normal", {30'b0, mode}, 32'd1);
        read_chk("R4 scratch0 untouched", 13'h1004, 8'h00);
        read_chk("R4 pdctl untouched", 13'h1002, 8'h00);
        read_chk("R4 scratch1 untouched", 13'h1005, 8'h00);
    endtask

    task automatic t_normal_regs;
        for (int i = 0; i < 4; i++) bus_write(13'h1004 + 13'(i), 8'(8'h11 * (i + 1)));
        for (int i = 0; i < 4; i++) read_chk("R12 scratch", 13'h1004 + 13'(i), 8'(8'h11 * (i + 1)));
        read_chk("R12 ctrl readback", 13'h1000, 8'h01);
        read_chk("R12 unmapped", 13'h0100, 8'h00);
        // R1: write strobe without chip enable
        @(negedge clk);
        addr = 13'h1004; wdata = 8'h99; we_n = 1'b0;
        wait_clk(4); we_n = 1'b1; wait_clk(6);
        read_chk("R1 no ce no write", 13'h1004, 8'h11);
        // R1: a read cycle with data present writes nothing
        wdata = 8'h77;
        read_chk("R1 read no write", 13'h1005, 8'h22);
    endtask

    task automatic t_dpd_enter;
        bus_write(13'h1000, 8'h02);
        @(negedge clk);
        addr = 13'h1001; wdata = 8'hFD; ce_n = 1'b0; we_n = 1'b0;
        wait_clk(4); we_n = 1'b1; wait_clk(6);
        chk("R6 waits for ce", {30'b0, mode}, 32'd1);
        chk("R6 power kept", {31'b0, pwr_en}, 32'd1);
        ce_n = 1'b1; wait_clk(6);
        chk("R6 entered dpd", {30'b0, mode}, 32'd2);
        chk("R6 power off", {31'b0, pwr_en}, 32'd0);
    endtask

    task automatic t_dpd_frozen;
        logic [7:0] d; logic oe;
        bus_write(13'h1004, 8'hEE);
        unlock(8'h01);
        chk("R7 unlock ignored", {30'b0, mode}, 32'd2);
        bus_read(13'h1004, d, oe);
        chk("R7 bus floats", {31'b0, oe}, 32'd0);
    endtask

    task automatic t_wake_reads;
        logic [7:0] d; logic oe;
        for (int i = 0; i < 3; i++) bus_read(13'h1FFF, d, oe);
        bus_read(13'h0000, d, oe);
        for (int i = 0; i < 3; i++) bus_read(13'h1FFF, d, oe);
        chk("R8 count restarted", {30'b0, mode}, 32'd2);
        bus_read(13'h1FFF, d, oe);
        chk("R8 wake by reads", {30'b0, mode}, 32'd1);
        chk("R10 power back", {31'b0, pwr_en}, 32'd1);
        read_chk("R10 scratch0 kept", 13'h1004, 8'h11);
        read_chk("R10 scratch3 kept", 13'h1007, 8'h44);
    endtask

    task automatic t_pin_wake;
        bus_write(13'h1002, 8'h01);
        unlock(8'h02);
        chk("R9 in dpd", {30'b0, mode}, 32'd2);
        pd_pin = 1'b1; wait_clk(6);
        chk("R9 wrong edge", {30'b0, mode}, 32'd2);
        pd_pin = 1'b0; wait_clk(6);
        chk("R9 falling wake", {30'b0, mode}, 32'd1);
        bus_write(13'h1002, 8'h00);
        unlock(8'h02);
        pd_pin = 1'b1; wait_clk(6);
        chk("R9 rising wake", {30'b0, mode}, 32'd1);
        pd_pin = 1'b0; wait_clk(6);
    endtask

    task automatic t_rstin;
        rstin_n = 1'b0; wait_clk(6);
        chk("R11 held mode", {30'b0, mode}, 32'd2);
        chk("R11 held power", {31'b0, pwr_en}, 32'd0);
        rstin_n = 1'b1; wait_clk(6);
        chk("R11 released", {30'b0, mode}, 32'd0);
        unlock(8'h01);
        read_chk("R10 kept after pin", 13'h1006, 8'h33);
    endtask

    task automatic t_dpd_from_reset;
        logic [7:0] d; logic oe;
        unlock(8'h00);
        chk("R2 unlock reset", {30'b0, mode}, 32'd0);
        unlock(8'h02);
        chk("R6 dpd from reset", {30'b0, mode}, 32'd2);
        for (int i = 0; i < 4; i++) bus_read(13'h1FFF, d, oe);
        chk("R10 back to reset", {30'b0, mode}, 32'd0);
        read_chk("R5 zero after wake", 13'h1004, 8'h00);
    endtask

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset_state();
        t_reset_writes();
        t_bad_unlock();
        t_unlock();
        t_normal_regs();
        t_dpd_enter();
        t_dpd_frozen();
        t_wake_reads();
        t_pin_wake();
        t_rstin();
        t_dpd_from_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule